// File: doc/BRIEF.md
# Clock-Control Register Slave on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C) that keeps a small bank of 8-bit control registers for a clock generator. The registers hold per-output clock enables and a frequency-select field. A fast system clock samples the bus clock and data lines through a synchronizer and a glitch filter. The block detects START and STOP conditions, shifts bytes in and out most significant bit first, and answers on the data line only through an open-drain pull-down enable.

A write transaction carries the write address. Two framing bytes follow, a command byte and a count byte. The block acknowledges both and stores neither. Every later byte goes into the next register, starting from register 0. A read transaction sends the registers back from register 0 onward until the controller declines a byte. No pointer register exists: every transaction starts again at register 0. The full register contents are available on a parallel bus for the clock logic to use.

Top module: `clkctl_i2c_regs`

## Requirements
- R1: After reset, register 0 (frequency select, bits 7:0 of the parallel bus) reads 0x00, registers 1 to 5 read 0xFF (all clock outputs enabled), and the SDA pull-down enable is low.
- R2: The device address is 7'b1101001. The block pulls SDA low during the ninth clock after the address byte 0xD2 (write) or 0xD3 (read).
- R3: After any other address byte the block does not acknowledge. It ignores all further bytes, leaving its registers unchanged and SDA released, until the next START.
- R4: In a write, the first two bytes after the address are acknowledged and are not stored in any register.
- R5: In a write, the third and later bytes are received MSB first and stored in registers 0, 1, 2 and onward, in order. Each is acknowledged. A register changes only on a rising edge of the filtered SCL.
- R6: Write data bytes beyond register 5 are acknowledged and discarded.
- R7: After a read address, the block drives register 0, then 1, 2 and onward, MSB first. SDA changes only after SCL falls, and every read transaction, including one after a repeated START, begins at register 0.
- R8: Read bytes beyond register 5 return 0xFF.
- R9: When the controller leaves SDA high in the ninth clock of a read byte (no acknowledge), the block releases SDA and drives nothing more until STOP or START.
- R10: A STOP ends a write. The next write again stores its first data byte in register 0.
- R11: A high pulse on SCL shorter than FILT_LEN system-clock cycles is not taken as a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_o | output | 8*NREG | Register contents; register n occupies bits 8n+7:8n |

## Verification
The checker watches reset and register values and the times at which the pull-down enable and the registers change. On every cycle it requires that the pull-down enable moves only after a filtered SCL falling edge or a bus condition, that registers change only on a filtered SCL rising edge, and that nothing is driven or written once a transaction has been rejected. Address matching, the discarding of the two framing bytes, the order of register writes and reads, the 0xFF fill past the last register, the release after a missing acknowledge, the restart at register 0 and the rejection of short SCL glitches depend on whole byte sequences. Only the bench scenarios can show them, with the reference register image compared on every clock.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_IGNORE
   } bus_state_e;
endpackage

// File: rtl/clkctl_pin_filter.sv
// Synchronizer followed by a persistence filter and edge detector for one bus line.
module clkctl_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter bit RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkctl_pin_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 0) begin : g_bad_filt
      $error("clkctl_pin_filter: FILT_LEN must not be negative");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   level_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RESET_LEVEL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN <= 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q <= RESET_LEVEL;
         else        level_q <= synced;
      end
   end else begin : g_filt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= RESET_LEVEL;
            cnt_q   <= '0;
         end else if (synced == level_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            level_q <= synced;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RESET_LEVEL;
      else        prev_q <= level_q;
   end

   assign level_o = level_q;
   assign rise_o  = level_q & ~prev_q;
   assign fall_o  = ~level_q & prev_q;
endmodule

// File: rtl/clkctl_regbank.sv
// Control register bank with reset image, one write port and a 0xFF-filled read port.
module clkctl_regbank #(
   parameter int                 NREG    = 6,
   parameter int                 IW      = $clog2(NREG + 1),
   parameter logic [8*NREG-1:0]  RST_VAL = {{(NREG-1){8'hFF}}, 8'h00}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IW-1:0]     widx,
   input  logic [7:0]        wdata,
   input  logic [IW-1:0]     ridx,
   output logic [7:0]        rdata,
   output logic [8*NREG-1:0] regs_o
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q <= RST_VAL[g*8 +: 8];
         else if (we && widx == IW'(g))     q <= wdata;
      end
      assign regs_o[g*8 +: 8] = q;
   end

   always_comb begin
      rdata = 8'hFF;
      for (int i = 0; i < NREG; i++) begin
         if (ridx == IW'(i)) rdata = regs_o[i*8 +: 8];
      end
   end
endmodule

// File: rtl/clkctl_i2c_regs.sv
// Two-wire bus target: address match, two framing bytes, streamed register write and read.
module clkctl_i2c_regs #(
   parameter logic [6:0]         DEV_ADDR    = 7'b1101001,
   parameter int                 NREG        = 6,
   parameter int                 SYNC_STAGES = 2,
   parameter int                 FILT_LEN    = 3,
   parameter logic [8*NREG-1:0]  RST_VAL     = {{(NREG-1){8'hFF}}, 8'h00}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [8*NREG-1:0] regs_o
);
   import clkctl_pkg::*;

   localparam int IW       = $clog2(NREG + 1);
   localparam int WIW      = $clog2(NREG + 3);
   localparam int N_FRAME  = 2;

   if (NREG < 1 || NREG > 64) begin : g_bad_nreg
      $error("clkctl_i2c_regs: NREG must lie in 1..64");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;

   clkctl_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RESET_LEVEL(1'b1)) u_scl (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   clkctl_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RESET_LEVEL(1'b1)) u_sda (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   logic start_evt, stop_evt;
   assign start_evt = sda_fall & scl_lvl;
   assign stop_evt  = sda_rise & scl_lvl;

   bus_state_e       state;
   logic [2:0]       bitcnt;
   logic [7:0]       shreg;
   logic [7:0]       txsh;
   logic             byte_done;
   logic             is_read;
   logic             m_ack;
   logic             sda_oe_q;
   logic [WIW-1:0]   wr_idx;
   logic [IW-1:0]    rd_idx;

   logic [7:0]       rx_next;
   logic             rx_last;
   logic [IW-1:0]    rd_inc;
   logic [WIW-1:0]   wr_inc;
   logic [IW-1:0]    rd_sel;
   logic [7:0]       rd_data;
   logic             wr_hit;
   logic [IW-1:0]    wr_reg;

   assign rx_next = {shreg[6:0], sda_lvl};
   assign rx_last = scl_rise && !byte_done && (bitcnt == 3'd7);
   assign rd_inc  = (rd_idx == IW'(NREG))           ? rd_idx : rd_idx + 1'b1;
   assign wr_inc  = (wr_idx == WIW'(NREG + N_FRAME)) ? wr_idx : wr_idx + 1'b1;
   assign rd_sel  = (state == ST_RD_ACK) ? rd_inc : '0;
   assign wr_reg  = IW'(wr_idx - WIW'(N_FRAME));
   assign wr_hit  = (state == ST_WR) && rx_last && !start_evt && !stop_evt &&
                    (wr_idx >= WIW'(N_FRAME)) && (wr_idx < WIW'(NREG + N_FRAME));

   clkctl_regbank #(.NREG(NREG), .IW(IW), .RST_VAL(RST_VAL)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(wr_hit), .widx(wr_reg), .wdata(rx_next),
      .ridx(rd_sel), .rdata(rd_data), .regs_o(regs_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         txsh      <= '0;
         byte_done <= 1'b0;
         is_read   <= 1'b0;
         m_ack     <= 1'b0;
         sda_oe_q  <= 1'b0;
         wr_idx    <= '0;
         rd_idx    <= '0;
      end else if (start_evt) begin
         state     <= ST_ADDR;
         bitcnt    <= '0;
         byte_done <= 1'b0;
         sda_oe_q  <= 1'b0;
      end else if (stop_evt) begin
         state     <= ST_IDLE;
         byte_done <= 1'b0;
         sda_oe_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (scl_rise && !byte_done) begin
                  shreg  <= rx_next;
                  bitcnt <= bitcnt + 1'b1;
                  if (rx_last) begin
                     is_read <= rx_next[0];
                     if (rx_next[7:1] == DEV_ADDR) byte_done <= 1'b1;
                     else                          state     <= ST_IGNORE;
                  end
               end else if (scl_fall && byte_done) begin
                  byte_done <= 1'b0;
                  sda_oe_q  <= 1'b1;
                  state     <= ST_ADDR_ACK;
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (is_read) begin
                     rd_idx   <= '0;
                     txsh     <= rd_data;
                     sda_oe_q <= ~rd_data[7];
                     state    <= ST_RD;
                  end else begin
                     wr_idx   <= '0;
                     sda_oe_q <= 1'b0;
                     state    <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               if (scl_rise && !byte_done) begin
                  shreg  <= rx_next;
                  bitcnt <= bitcnt + 1'b1;
                  if (rx_last) begin
                     byte_done <= 1'b1;
                     wr_idx    <= wr_inc;
                  end
               end else if (scl_fall && byte_done) begin
                  byte_done <= 1'b0;
                  sda_oe_q  <= 1'b1;
                  state     <= ST_WR_ACK;
               end
            end
            ST_WR_ACK: begin
               if (scl_fall) begin
                  sda_oe_q <= 1'b0;
                  bitcnt   <= '0;
                  state    <= ST_WR;
               end
            end
            ST_RD: begin
               if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     sda_oe_q <= 1'b0;
                     state    <= ST_RD_ACK;
                  end else begin
                     txsh     <= {txsh[6:0], 1'b0};
                     sda_oe_q <= ~txsh[6];
                     bitcnt   <= bitcnt + 1'b1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  m_ack <= ~sda_lvl;
               end else if (scl_fall) begin
                  if (m_ack) begin
                     rd_idx   <= rd_inc;
                     txsh     <= rd_data;
                     sda_oe_q <= ~rd_data[7];
                     bitcnt   <= '0;
                     state    <= ST_RD;
                  end else begin
                     state    <= ST_IGNORE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = sda_oe_q;
endmodule

// Timing checker bound to the top module.
module clkctl_i2c_regs_chk #(
   parameter int                NREG    = 6,
   parameter logic [8*NREG-1:0] RST_VAL = {{(NREG-1){8'hFF}}, 8'h00}
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sda_oe,
   input logic [8*NREG-1:0]      regs,
   input logic                   scl_rise,
   input logic                   scl_fall,
   input logic                   start_evt,
   input logic                   stop_evt,
   input clkctl_pkg::bus_state_e state
);
   // R1: reset image and released data line on the first cycle out of reset
   a_r1_reset_image: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (regs == RST_VAL));
   a_r1_reset_released: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !sda_oe);

   // R2 / R7: the pull-down moves only after SCL fell or on a bus condition
   a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

   // R5: registers are written only on a filtered SCL rising edge
   a_r5_write_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs) |-> $past(scl_rise));

   // R3 / R9: a rejected or finished transaction neither drives nor writes
   a_r3_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == clkctl_pkg::ST_IGNORE && $past(state == clkctl_pkg::ST_IGNORE))
      |-> (!sda_oe && $stable(regs)));
endmodule

bind clkctl_i2c_regs clkctl_i2c_regs_chk #(.NREG(NREG), .RST_VAL(RST_VAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .regs(regs_o),
   .scl_rise(scl_rise), .scl_fall(scl_fall),
   .start_evt(start_evt), .stop_evt(stop_evt), .state(state));

// File: tb/tb_clkctl_i2c_regs.sv
module tb_clkctl_i2c_regs;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 12;   // quarter bus-bit, in system clocks
   localparam int NREG       = 6;
   localparam int WD_LIMIT   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_bus;
   logic [8*NREG-1:0] regs;

   assign sda_bus = sda_m & ~sda_oe;

   clkctl_i2c_regs dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .regs_o(regs));

   always #(CLK_PERIOD/2) clk = ~clk;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   bit  cmp_hold = 1'b1;
   logic [7:0] model [NREG];

   function automatic logic [8*NREG-1:0] mvec();
      logic [8*NREG-1:0] v;
      for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Reference register image compared on every clock (R5)
   always @(negedge clk) begin
      if (rst_n && !cmp_hold && !done) begin
         checks++;
         if (regs !== mvec()) begin
            errors++;
            $display("FAIL R5 register image at %0t: actual=%0h expected=%0h",
                     $time, regs, mvec());
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   // Controller sends a byte; widx >= 0 marks the register the model expects it in.
   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int widx,
                            input string req, input int glitch_bit = -1);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i];
         if (i == glitch_bit) begin
            tick(4); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q - 6);
         end else begin
            tick(Q);
         end
         if (i == 0) cmp_hold = 1'b1;
         scl_m = 1'b1; tick(Q);
         chk(sda_oe == 1'b0, req, "data line free during controller bit", 64'(sda_oe), 64'd0);
         if (i == 0) begin
            if (widx >= 0 && widx < NREG) model[widx] = b;
            cmp_hold = 1'b0;
         end
         tick(Q);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      chk(sda_oe == exp_ack, req, $sformatf("ack after byte %02h", b), 64'(sda_oe), 64'(exp_ack));
      tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
      logic [7:0] got;
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; tick(Q);
         scl_m = 1'b1; tick(Q);
         got[i] = sda_bus;
         tick(Q);
         scl_m = 1'b0; tick(Q);
      end
      chk(got == exp, req, "read byte", 64'(got), 64'(exp));
      sda_m = mack ? 1'b0 : 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      chk(sda_oe == 1'b0, req, "released in controller ack bit", 64'(sda_oe), 64'd0);
      tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   initial begin : watchdog
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      model[0] = 8'h00;
      for (int i = 1; i < NREG; i++) model[i] = 8'hFF;
      tick(5);
      rst_n = 1'b1;
      tick(3);
      // R1: reset image and released line
      chk(regs == mvec(), "R1", "reset register image", 64'(regs), 64'(mvec()));
      chk(sda_oe == 1'b0, "R1", "reset pull-down", 64'(sda_oe), 64'd0);
      cmp_hold = 1'b0;

      // R2 R4 R5: write address, two framing bytes, three data bytes
      bus_start();
      send_byte(8'hD2, 1'b1, -1, "R2");
      send_byte(8'h00, 1'b1, -1, "R4");
      send_byte(8'h03, 1'b1, -1, "R4");
      send_byte(8'hA5, 1'b1, 0, "R5");
      send_byte(8'h3C, 1'b1, 1, "R5");
      send_byte(8'h81, 1'b1, 2, "R5");
      bus_stop();
      chk(regs[7:0] == 8'hA5, "R4", "reg0 holds first data byte, not framing", 64'(regs[7:0]), 64'hA5);
      chk(regs[23:16] == 8'h81, "R5", "reg2", 64'(regs[23:16]), 64'h81);
      chk(regs[31:24] == 8'hFF, "R5", "reg3 untouched", 64'(regs[31:24]), 64'hFF);

      // R2 R7 R8 R9: read all registers, two past the end, then decline
      bus_start();
      send_byte(8'hD3, 1'b1, -1, "R2");
      for (int i = 0; i < NREG; i++) recv_byte(model[i], 1'b1, "R7");
      recv_byte(8'hFF, 1'b1, "R8");
      recv_byte(8'hFF, 1'b0, "R8");
      send_byte(8'hFF, 1'b0, -1, "R9");
      bus_stop();

      // R3: foreign address, then bytes that must be ignored
      bus_start();
      send_byte(8'hD6, 1'b0, -1, "R3");
      send_byte(8'h00, 1'b0, -1, "R3");
      send_byte(8'h00, 1'b0, -1, "R3");
      send_byte(8'h55, 1'b0, -1, "R3");
      bus_stop();
      chk(regs == mvec(), "R3", "registers after foreign address", 64'(regs), 64'(mvec()));

      // R6 R7: write past the end, then repeated START into a read
      bus_start();
      send_byte(8'hD2, 1'b1, -1, "R2");
      send_byte(8'h12, 1'b1, -1, "R4");
      send_byte(8'h34, 1'b1, -1, "R4");
      for (int i = 0; i < NREG + 2; i++) send_byte(8'h10 + 8'(i), 1'b1, i, "R6");
      chk(regs[47:40] == 8'h15, "R6", "last register after overrun", 64'(regs[47:40]), 64'h15);
      bus_start();
      send_byte(8'hD3, 1'b1, -1, "R7");
      recv_byte(8'h10, 1'b0, "R7");
      bus_stop();

      // R10: a second write after STOP restarts at register 0
      bus_start();
      send_byte(8'hD2, 1'b1, -1, "R10");
      send_byte(8'h00, 1'b1, -1, "R10");
      send_byte(8'h00, 1'b1, -1, "R10");
      send_byte(8'h77, 1'b1, 0, "R10");
      bus_stop();
      bus_start();
      send_byte(8'hD2, 1'b1, -1, "R10");
      send_byte(8'h00, 1'b1, -1, "R10");
      send_byte(8'h00, 1'b1, -1, "R10");
      send_byte(8'h99, 1'b1, 0, "R10");
      bus_stop();
      chk(regs[7:0] == 8'h99, "R10", "reg0 after second write", 64'(regs[7:0]), 64'h99);
      chk(regs[15:8] == 8'h11, "R10", "reg1 kept", 64'(regs[15:8]), 64'h11);

      // R11: short SCL pulse inside a data byte is not a clock
      bus_start();
      send_byte(8'hD2, 1'b1, -1, "R11");
      send_byte(8'h00, 1'b1, -1, "R11");
      send_byte(8'h00, 1'b1, -1, "R11");
      send_byte(8'hC3, 1'b1, 0, "R11", 4);
      bus_stop();
      chk(regs[7:0] == 8'hC3, "R11", "reg0 after glitched byte", 64'(regs[7:0]), 64'hC3);
      chk(regs == mvec(), "R11", "full image after glitch", 64'(regs), 64'(mvec()));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule